// File: doc/BRIEF.md
# Multi-Device Synapse Update Arbiter

One synapse weight is held by several programmable conductance devices. This block turns each weight-update request for that synapse into a programming command for exactly one of those devices. A wrapping selection counter chooses the device. It advances by a configurable step after every accepted update. Two independent gating counters, one for increases and one for decreases, thin out how often each kind of event may reach the devices. This lets a designer balance devices whose increase and decrease responses are very unequal.

A request carries a signed fixed-point weight change and a step size ε. The command gives a device index, a pulse kind (grow or reset) and a pulse count. In the single-set arrangement, every device belongs to one pool: growth pulses raise the weight and a single reset pulse lowers it. In the paired arrangement, the devices split into a positive half and a negative half, and every command is a growth pulse. In that arrangement the block also raises a refresh request when either half's summed weight nears saturation. The device count, the selection step, both gating lengths and the arrangement are configuration inputs, held steady between resets.

Top module: `synapse_update_arbiter`

## Requirements
- R1: A synchronous active-high reset sets the selection counter and both gating counters to 1 and clears cmd_valid and refresh_req. Device index equals selection value minus 1, so the first update after reset addresses device 0.
- R2: The selection counter runs over 1..L, where L = cfg_ndev in single-set mode and L = cfg_ndev/2 in paired mode. After each accepted update it moves forward by cfg_step, modulo L.
- R3: The growth gating counter runs 1..cfg_plen and advances on every accepted update. An update may issue a growth command only while this counter equals 1.
- R4: The decrease gating counter runs 1..cfg_dlen and advances on every accepted update. An update may issue a decrease command only while this counter equals 1. In paired mode, the decrease command is the negative-half growth command.
- R5: With cfg_ndev = 1, both gates are bypassed, so every eligible update issues its command.
- R6: For up_dw > 0, the pulse count is floor((2·up_dw + up_eps) / (2·up_eps)), which is up_dw/ε rounded half up. The command is a growth pulse (cmd_depress = 0) to device selection−1. A count of 0 issues no command.
- R7: In single-set mode (cfg_diff = 0), an update with 2·up_dw < −up_eps issues one reset pulse (cmd_depress = 1, cmd_pulses = 1) to device selection−1. A smaller decrease issues nothing.
- R8: In paired mode (cfg_diff = 1), positive updates address device selection−1 and negative updates address device cfg_ndev/2 + selection−1. Both are growth pulses, with a count of round-half-up(|up_dw|/ε).
- R9: refresh_req is high for one cycle after an accepted update, only in paired mode, and only when g_pos_sum or g_neg_sum exceeds 230, which is floor(0.9·2^8) with 8 fraction bits.
- R10: up_ready is always 1. The command appears one cycle after acceptance. Without an accepted update there is no command, and no counter moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ndev | input | 4 | Devices per synapse (1..8) |
| cfg_diff | input | 1 | 1 = paired halves, 0 = single set |
| cfg_step | input | 4 | Selection step, co-prime with L |
| cfg_plen | input | 4 | Growth gating length (>=1) |
| cfg_dlen | input | 4 | Decrease gating length (>=1) |
| up_valid | input | 1 | Update request valid |
| up_ready | output | 1 | Update request accepted |
| up_dw | input | 12 | Signed weight change, 8 fraction bits |
| up_eps | input | 12 | Step size ε, 8 fraction bits, nonzero |
| g_pos_sum | input | 10 | Positive-half summed weight |
| g_neg_sum | input | 10 | Negative-half summed weight |
| cmd_valid | output | 1 | Programming command valid |
| cmd_dev | output | 3 | Device index |
| cmd_depress | output | 1 | 1 = reset pulse, 0 = growth pulse |
| cmd_pulses | output | 12 | Pulse count |
| refresh_req | output | 1 | Refresh request for the paired halves |

## Verification
The assertions assume that configuration changes only while reset is held. They also assume cfg_ndev is in 1..8 and even in paired mode, that cfg_step lies in 1..L, that both gating lengths are at least 1, and that up_eps is nonzero. Under those conditions, counter values stay within their lengths, and every command index falls below the device count. The bench writes new configuration only inside its reset routine and keeps every update inside the stated ranges. It also drives up_valid low throughout reset.

// File: rtl/sua_pkg.sv
package sua_pkg;

    typedef enum logic {
        PULSE_GROW  = 1'b0,
        PULSE_RESET = 1'b1
    } pulse_e;

endpackage

// File: rtl/sua_wrap_ctr.sv
module sua_wrap_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] len,
    input  logic [W-1:0] step,
    output logic [W-1:0] val
);

    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   pos;

    always_comb begin
        cnt_d = cnt_q;
        pos   = {1'b0, cnt_q} - (W+1)'(1) + {1'b0, step};
        if (pos >= {1'b0, len}) begin
            pos = pos - {1'b0, len};
        end
        if (adv) begin
            cnt_d = pos[W-1:0] + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= W'(1);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign val = cnt_q;

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(val));

    // R2
    wrap_range_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (val != '0) && (val <= $past(len)));

endmodule

// File: rtl/sua_pulse_quant.sv
module sua_pulse_quant #(
    parameter int DW_W = 12
) (
    input  logic signed [DW_W-1:0] dw,
    input  logic        [DW_W-1:0] eps,
    output logic        [DW_W-1:0] steps,
    output logic                   big_drop
);

    logic [DW_W-1:0] mag;
    logic [DW_W+1:0] num_d, den_d, quo_d;

    always_comb begin
        mag      = dw[DW_W-1] ? DW_W'(-dw) : DW_W'(dw);
        num_d    = (DW_W+2)'({mag, 1'b0}) + (DW_W+2)'(eps);
        den_d    = (DW_W+2)'({eps, 1'b0});
        quo_d    = (den_d == '0) ? '0 : num_d / den_d;
        steps    = quo_d[DW_W-1:0];
        big_drop = dw[DW_W-1] && ({mag, 1'b0} > {1'b0, eps});
    end

endmodule

// File: rtl/synapse_update_arbiter.sv
module synapse_update_arbiter
    import sua_pkg::*;
#(
    parameter int NDEV_MAX = 8,
    parameter int GLEN_MAX = 8,
    parameter int DW_W     = 12,
    parameter int FRAC     = 8,
    parameter int SUM_W    = FRAC + 2,
    parameter int NW       = $clog2(NDEV_MAX + 1),
    parameter int IW       = $clog2(NDEV_MAX),
    parameter int GW       = $clog2(GLEN_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NW-1:0]          cfg_ndev,
    input  logic                   cfg_diff,
    input  logic [NW-1:0]          cfg_step,
    input  logic [GW-1:0]          cfg_plen,
    input  logic [GW-1:0]          cfg_dlen,
    input  logic                   up_valid,
    output logic                   up_ready,
    input  logic signed [DW_W-1:0] up_dw,
    input  logic [DW_W-1:0]        up_eps,
    input  logic [SUM_W-1:0]       g_pos_sum,
    input  logic [SUM_W-1:0]       g_neg_sum,
    output logic                   cmd_valid,
    output logic [IW-1:0]          cmd_dev,
    output logic                   cmd_depress,
    output logic [DW_W-1:0]        cmd_pulses,
    output logic                   refresh_req
);

    localparam int REF_LIM = (9 * (1 << FRAC)) / 10;
    localparam int NGATE   = 2;

    typedef struct packed {
        logic            valid;
        logic [IW-1:0]   dev;
        pulse_e          kind;
        logic [DW_W-1:0] pulses;
        logic            refresh;
    } out_t;

    out_t            st_d, st_q;
    logic            accept;
    logic [NW-1:0]   sel_len, sel_val;
    logic [GW-1:0]   gate_len [NGATE];
    logic [GW-1:0]   gate_val [NGATE];
    logic [DW_W-1:0] q_steps;
    logic            q_drop;
    logic            bypass, grow_ok, drop_ok, is_neg;
    logic [IW-1:0]   dev_base, half;

    // Requests are taken every cycle; the command register never stalls.
    assign up_ready = 1'b1;
    assign accept   = up_valid & up_ready;
    assign sel_len  = cfg_diff ? (cfg_ndev >> 1) : cfg_ndev;

    sua_wrap_ctr #(.W(NW)) u_sel (
        .clk  (clk),
        .rst  (rst),
        .adv  (accept),
        .len  (sel_len),
        .step (cfg_step),
        .val  (sel_val)
    );

    assign gate_len[0] = cfg_plen;
    assign gate_len[1] = cfg_dlen;

    for (genvar g = 0; g < NGATE; g++) begin : g_gate
        sua_wrap_ctr #(.W(GW)) u_gate (
            .clk  (clk),
            .rst  (rst),
            .adv  (accept),
            .len  (gate_len[g]),
            .step (GW'(1)),
            .val  (gate_val[g])
        );
    end

    sua_pulse_quant #(.DW_W(DW_W)) u_quant (
        .dw       (up_dw),
        .eps      (up_eps),
        .steps    (q_steps),
        .big_drop (q_drop)
    );

    always_comb begin
        bypass   = (cfg_ndev == NW'(1));
        grow_ok  = bypass || (gate_val[0] == GW'(1));
        drop_ok  = bypass || (gate_val[1] == GW'(1));
        is_neg   = up_dw[DW_W-1];
        dev_base = IW'(sel_val - NW'(1));
        half     = IW'(cfg_ndev >> 1);

        st_d = '0;
        if (accept) begin
            if (!is_neg && (q_steps != '0) && grow_ok) begin
                st_d.valid  = 1'b1;
                st_d.dev    = dev_base;
                st_d.kind   = PULSE_GROW;
                st_d.pulses = q_steps;
            end else if (!cfg_diff && q_drop && drop_ok) begin
                st_d.valid  = 1'b1;
                st_d.dev    = dev_base;
                st_d.kind   = PULSE_RESET;
                st_d.pulses = DW_W'(1);
            end else if (cfg_diff && is_neg && (q_steps != '0) && drop_ok) begin
                st_d.valid  = 1'b1;
                st_d.dev    = dev_base + half;
                st_d.kind   = PULSE_GROW;
                st_d.pulses = q_steps;
            end
            st_d.refresh = cfg_diff && ((g_pos_sum > SUM_W'(REF_LIM)) ||
                                        (g_neg_sum > SUM_W'(REF_LIM)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_valid   = st_q.valid;
    assign cmd_dev     = st_q.dev;
    assign cmd_depress = (st_q.kind == PULSE_RESET);
    assign cmd_pulses  = st_q.pulses;
    assign refresh_req = st_q.refresh;

    // R10
    cmd_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(accept));

    // R7
    single_reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_depress) |-> (cmd_pulses == DW_W'(1)));

    // R8
    paired_grow_only_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && $past(cfg_diff)) |-> !cmd_depress);

    // R9
    refresh_paired_only_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_req |-> ($past(cfg_diff) && $past(accept)));

    // R1
    dev_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (NW'(cmd_dev) < $past(cfg_ndev)));

endmodule

// File: tb/synapse_update_arbiter_bench.sv
module synapse_update_arbiter_bench;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [3:0]         cfg_ndev = 4'd4;
    logic               cfg_diff = 1'b0;
    logic [3:0]         cfg_step = 4'd1;
    logic [3:0]         cfg_plen = 4'd1;
    logic [3:0]         cfg_dlen = 4'd1;
    logic               up_valid = 1'b0;
    logic               up_ready;
    logic signed [11:0] up_dw = '0;
    logic [11:0]        up_eps = 12'd16;
    logic [9:0]         g_pos_sum = '0;
    logic [9:0]         g_neg_sum = '0;
    logic               cmd_valid;
    logic [2:0]         cmd_dev;
    logic               cmd_depress;
    logic [11:0]        cmd_pulses;
    logic               refresh_req;

    always #2 clk = ~clk;

    synapse_update_arbiter u_synapse_update_arbiter (
        .clk (clk), .rst (rst),
        .cfg_ndev (cfg_ndev), .cfg_diff (cfg_diff), .cfg_step (cfg_step),
        .cfg_plen (cfg_plen), .cfg_dlen (cfg_dlen),
        .up_valid (up_valid), .up_ready (up_ready),
        .up_dw (up_dw), .up_eps (up_eps),
        .g_pos_sum (g_pos_sum), .g_neg_sum (g_neg_sum),
        .cmd_valid (cmd_valid), .cmd_dev (cmd_dev), .cmd_depress (cmd_depress),
        .cmd_pulses (cmd_pulses), .refresh_req (refresh_req)
    );

    typedef struct {
        logic  v;
        int    dev;
        logic  dep;
        int    cnt;
        logic  rf;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    int   m_sel, m_pc, m_dc;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: compares registered outputs after each edge with the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(cmd_valid === e.v, e.tag, "cmd_valid", int'(cmd_valid), int'(e.v));
                if (e.v && cmd_valid === 1'b1) begin
                    chk(int'(cmd_dev) == e.dev, e.tag, "cmd_dev", int'(cmd_dev), e.dev);
                    chk(cmd_depress === e.dep, e.tag, "cmd_depress", int'(cmd_depress), int'(e.dep));
                    chk(int'(cmd_pulses) == e.cnt, e.tag, "cmd_pulses", int'(cmd_pulses), e.cnt);
                end
                chk(refresh_req === e.rf, e.tag, "refresh_req", int'(refresh_req), int'(e.rf));
            end
        end
    end

    task automatic do_reset(input int n, input bit diff, input int step,
                            input int plen, input int dlen);
        up_valid = 1'b0;
        rst      = 1'b1;
        cfg_ndev = 4'(n);
        cfg_diff = diff;
        cfg_step = 4'(step);
        cfg_plen = 4'(plen);
        cfg_dlen = 4'(dlen);
        repeat (3) @(posedge clk);
        #1;
        rst   = 1'b0;
        m_sel = 1;
        m_pc  = 1;
        m_dc  = 1;
        // R1: outputs cleared after reset
        chk(cmd_valid === 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
        chk(refresh_req === 1'b0, "R1", "refresh after reset", int'(refresh_req), 0);
    endtask

    // Driver: presents one update, predicts the result and queues it.
    task automatic upd(input int dw, input int eps, input int ps, input int ns,
                       input string tag);
        exp_t e;
        int   l, mag, qn;
        bit   byp, gok, dok;
        l   = cfg_diff ? int'(cfg_ndev) / 2 : int'(cfg_ndev);
        byp = (cfg_ndev == 4'd1);
        gok = byp || (m_pc == 1);
        dok = byp || (m_dc == 1);
        mag = (dw < 0) ? -dw : dw;
        qn  = (2 * mag + eps) / (2 * eps);
        e.v = 0; e.dev = 0; e.dep = 0; e.cnt = 0; e.tag = tag;
        if (dw > 0 && qn > 0 && gok) begin
            e.v = 1; e.dev = m_sel - 1; e.cnt = qn;
        end else if (!cfg_diff && 2 * dw < -eps && dok) begin
            e.v = 1; e.dev = m_sel - 1; e.dep = 1; e.cnt = 1;
        end else if (cfg_diff && dw < 0 && qn > 0 && dok) begin
            e.v = 1; e.dev = int'(cfg_ndev) / 2 + m_sel - 1; e.cnt = qn;
        end
        e.rf = cfg_diff && (ps > 230 || ns > 230);
        m_sel = ((m_sel - 1 + int'(cfg_step)) % l) + 1;
        m_pc  = (m_pc == int'(cfg_plen)) ? 1 : m_pc + 1;
        m_dc  = (m_dc == int'(cfg_dlen)) ? 1 : m_dc + 1;
        up_dw     = 12'(dw);
        up_eps    = 12'(eps);
        g_pos_sum = 10'(ps);
        g_neg_sum = 10'(ns);
        up_valid  = 1'b1;
        @(posedge clk);
        #1;
        q.push_back(e);
        up_valid = 1'b0;
    endtask

    task automatic idle(input string tag);
        exp_t e;
        e.v = 0; e.dev = 0; e.dep = 0; e.cnt = 0; e.rf = 0; e.tag = tag;
        @(posedge clk);
        #1;
        q.push_back(e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Single set, N=4, step 3, no gating: R1 R2 R6
        do_reset(4, 1'b0, 3, 1, 1);
        chk(up_ready === 1'b1, "R10", "up_ready", int'(up_ready), 1);
        for (int i = 0; i < 5; i++) upd(32, 16, 0, 0, "R2");
        // Rounding corners R6
        upd(24, 16, 0, 0, "R6");
        upd(23, 16, 0, 0, "R6");
        upd(7, 16, 0, 0, "R6");
        upd(8, 16, 0, 0, "R6");
        upd(1000, 3, 0, 0, "R6");
        // Decrease threshold R7, and no refresh outside paired mode R9
        upd(-8, 16, 300, 300, "R7");
        upd(-9, 16, 300, 300, "R7");
        upd(-200, 16, 0, 0, "R7");
        // Idle cycles keep counters still R10
        for (int i = 0; i < 3; i++) idle("R10");
        upd(16, 16, 0, 0, "R10");

        // Gating: N=5 step 2, growth every 2nd, decrease every 3rd: R3 R4
        do_reset(5, 1'b0, 2, 2, 3);
        for (int i = 0; i < 8; i++) upd((i % 2 == 0) ? 48 : -48, 16, 0, 0, "R3");
        for (int i = 0; i < 6; i++) upd(-40, 16, 0, 0, "R4");

        // N=1 bypasses gates R5
        do_reset(1, 1'b0, 1, 3, 3);
        for (int i = 0; i < 6; i++) upd((i % 2 == 0) ? 20 : -30, 16, 0, 0, "R5");

        // Paired mode, N=6, step 2, decrease every 2nd: R8 R9
        do_reset(6, 1'b1, 2, 1, 2);
        upd(32, 16, 230, 0, "R8");
        upd(-32, 16, 0, 231, "R9");
        upd(-40, 16, 231, 0, "R8");
        upd(-7, 16, 0, 0, "R8");
        upd(-24, 16, 230, 230, "R9");
        for (int i = 0; i < 6; i++) upd((i % 3 == 0) ? -16 : 40, 16, 0, 0, "R8");
        idle("R10");

        repeat (4) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule